// File: doc/BRIEF.md
# SPI Data Register Byte Packer

This block connects a 32-bit register access port to the 8-bit transmit and receive queues of a serial flash controller. A single register access moves several bytes at once. A write to the main transmit-data address pushes a fixed number of bytes into the transmit queue. That number is set by a parameter. Three partial-word addresses push exactly one, two or three bytes. A read of the receive-data address pops up to the same fixed number of bytes and packs them into one word. A configuration bit selects which end of the word is used first.

On the other side, a serial shifting engine takes transmit bytes one at a time and delivers received bytes one at a time. When the engine asks for a byte from an empty transmit queue, a sticky underflow flag is set. When it delivers a byte into a full receive queue, a sticky overflow flag is set and the byte is lost. Software clears each flag by writing one to its bit.

Register accesses are decoded into named access kinds: NONE, CFG_WR, CFG_RD, STAT_WR, STAT_RD, TX_WR, TX1_WR, TX2_WR, TX3_WR, RX_RD, THR_WR, THR_RD and OTHER. Every access completes in the cycle it is presented. Read data is returned combinationally in that cycle. Any pop caused by the read takes effect at the clock edge that ends the cycle.

Top module: `spi_word_packer`

## Requirements
- R1: After reset, both flags are 0. Status (0x04) reads 0. Configuration (0x00) reads 0. The receive threshold (0x10) reads 1. A receive-data read returns 0.
- R2: A write to 0x08 pushes XFER_BYTES bytes when configuration bit 26 is 0. Byte k is taken from write-data bits [8k+7:8k], starting at k=0.
- R3: When configuration bit 26 is 1, each transmit write takes its bytes from bits [31:24] downward, one byte lane per pushed byte.
- R4: Writes to 0x80, 0x84 and 0x88 push exactly 1, 2 and 3 bytes, using the same byte order as R2 and R3.
- R5: Bytes are pushed only while the transmit queue (FIFO_DEPTH entries) has room. Bytes beyond the free space are discarded.
- R6: A read of 0x0C pops min(XFER_BYTES, stored count) bytes in the same cycle. Popped byte i is placed at bits 8*i when bit 26 is 0, or at bits 8*(3-i) when bit 26 is 1. Byte lanes with no popped byte read as zero.
- R7: While sh_tx_req is high and the transmit queue holds data, sh_tx_data shows the oldest byte. That byte is removed at the clock edge, so bytes leave in first-in first-out order.
- R8: sh_tx_req on an empty transmit queue sets the sticky underflow flag (status bit 0 and tx_underflow) from the next cycle. Nothing is removed.
- R9: sh_rx_valid on a full receive queue sets the sticky overflow flag (status bit 1 and rx_overflow) from the next cycle. The byte is dropped.
- R10: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged.
- R11: The receive threshold register at 0x10 can be written and read back, and it resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| sh_tx_req | input | 1 | Shifter takes one transmit byte |
| sh_tx_data | output | 8 | Oldest transmit byte |
| sh_rx_valid | input | 1 | Shifter delivers one received byte |
| sh_rx_data | input | 8 | Received byte |
| tx_underflow | output | 1 | Sticky transmit underflow flag |
| rx_overflow | output | 1 | Sticky receive overflow flag |

## Verification
The bench builds the block with XFER_BYTES = 4 and FIFO_DEPTH = 8. With four bytes per access, every byte lane takes part in both orderings. A read can also come back partly filled, with zero lanes. With only eight entries, the queues fill after two full-word writes or eight delivered bytes. The full-queue discard, the overflow drop and the underflow on a drained queue can therefore be reached in a few accesses.

// File: rtl/spi_packer_pkg.sv
package spi_packer_pkg;

    // Number of bytes in flight per access (0..4)
    typedef logic [2:0] lane_cnt_t;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_CFG_WR,
        ACC_CFG_RD,
        ACC_STAT_WR,
        ACC_STAT_RD,
        ACC_TX_WR,
        ACC_TX1_WR,
        ACC_TX2_WR,
        ACC_TX3_WR,
        ACC_RX_RD,
        ACC_THR_WR,
        ACC_THR_RD,
        ACC_OTHER
    } acc_kind_t;

    localparam logic [7:0] OFS_CFG  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_TXD  = 8'h08;
    localparam logic [7:0] OFS_RXD  = 8'h0C;
    localparam logic [7:0] OFS_THR  = 8'h10;
    localparam logic [7:0] OFS_TX1  = 8'h80;
    localparam logic [7:0] OFS_TX2  = 8'h84;
    localparam logic [7:0] OFS_TX3  = 8'h88;

    localparam int ORDER_BIT = 26;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
    import spi_packer_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int PUSH_W = 4,
    parameter int POP_W  = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  lane_cnt_t                push_want,
    input  logic [PUSH_W-1:0][7:0]   push_data,
    output lane_cnt_t                push_done,
    input  lane_cnt_t                pop_want,
    output lane_cnt_t                pop_done,
    output logic [POP_W-1:0][7:0]    pop_data,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] free;

    always_comb begin
        free      = LW'(DEPTH) - level;
        push_done = (LW'(push_want) > free)  ? lane_cnt_t'(free)  : push_want;
        pop_done  = (LW'(pop_want)  > level) ? lane_cnt_t'(level) : pop_want;
        for (int i = 0; i < POP_W; i++) begin
            pop_data[i] = (LW'(i) < level) ? mem[rp + AW'(i)] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_W; i++) begin
            if (lane_cnt_t'(i) < push_done) begin
                mem[wp + AW'(i)] <= push_data[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + AW'(push_done);
            rp    <= rp + AW'(pop_done);
            level <= level + LW'(push_done) - LW'(pop_done);
        end
    end

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LW'(DEPTH) && pop_want == '0) |=> level == LW'(DEPTH));

endmodule

// File: rtl/spi_lane_order.sv
module spi_lane_order
    import spi_packer_pkg::*;
(
    input  logic             msb_first,
    input  logic [31:0]      tx_word,
    output logic [3:0][7:0]  tx_bytes,
    input  logic [3:0][7:0]  rx_bytes,
    input  lane_cnt_t        rx_take,
    output logic [31:0]      rx_word
);
    for (genvar p = 0; p < 4; p++) begin : g_lane
        assign tx_bytes[p] = msb_first ? tx_word[8*(3-p) +: 8] : tx_word[8*p +: 8];
        assign rx_word[8*p +: 8] = msb_first
            ? ((lane_cnt_t'(3-p) < rx_take) ? rx_bytes[3-p] : 8'h00)
            : ((lane_cnt_t'(p)   < rx_take) ? rx_bytes[p]   : 8'h00);
    end
endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
    import spi_packer_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int XFER_BYTES = 1,
    parameter int FIFO_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              sh_tx_req,
    output logic [7:0]        sh_tx_data,
    input  logic              sh_rx_valid,
    input  logic [7:0]        sh_rx_data,
    output logic              tx_underflow,
    output logic              rx_overflow
);
    localparam int LW = $clog2(FIFO_DEPTH) + 1;
    localparam lane_cnt_t XFER = lane_cnt_t'(XFER_BYTES);

    acc_kind_t acc;
    logic [31:0]     cfg_q;
    logic [LW-1:0]   thr_q;
    logic            unf_q, ovf_q;

    lane_cnt_t       tx_want, tx_done, tx_pop_done;
    lane_cnt_t       rx_want, rx_take, rx_push_done;
    logic [3:0][7:0] tx_bytes, rx_bytes;
    logic [0:0][7:0] tx_head;
    logic [31:0]     rx_word;
    logic [LW-1:0]   tx_level, rx_level;

    // access decode
    always_comb begin
        acc = ACC_NONE;
        if (reg_valid) begin
            unique case (8'(reg_addr))
                OFS_CFG:  acc = reg_write ? ACC_CFG_WR  : ACC_CFG_RD;
                OFS_STAT: acc = reg_write ? ACC_STAT_WR : ACC_STAT_RD;
                OFS_TXD:  acc = reg_write ? ACC_TX_WR   : ACC_OTHER;
                OFS_RXD:  acc = reg_write ? ACC_OTHER   : ACC_RX_RD;
                OFS_THR:  acc = reg_write ? ACC_THR_WR  : ACC_THR_RD;
                OFS_TX1:  acc = reg_write ? ACC_TX1_WR  : ACC_OTHER;
                OFS_TX2:  acc = reg_write ? ACC_TX2_WR  : ACC_OTHER;
                OFS_TX3:  acc = reg_write ? ACC_TX3_WR  : ACC_OTHER;
                default:  acc = ACC_OTHER;
            endcase
        end
    end

    // per-access byte counts and read data
    always_comb begin
        tx_want   = '0;
        rx_want   = '0;
        reg_rdata = '0;
        unique case (acc)
            ACC_TX_WR:   tx_want = XFER;
            ACC_TX1_WR:  tx_want = 3'd1;
            ACC_TX2_WR:  tx_want = 3'd2;
            ACC_TX3_WR:  tx_want = 3'd3;
            ACC_RX_RD: begin
                rx_want   = XFER;
                reg_rdata = rx_word;
            end
            ACC_CFG_RD:  reg_rdata = cfg_q;
            ACC_STAT_RD: reg_rdata = {30'd0, ovf_q, unf_q};
            ACC_THR_RD:  reg_rdata = 32'(thr_q);
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            thr_q <= LW'(1);
            unf_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (acc == ACC_CFG_WR) cfg_q <= reg_wdata;
            if (acc == ACC_THR_WR) thr_q <= reg_wdata[LW-1:0];
            unf_q <= (unf_q & ~((acc == ACC_STAT_WR) & reg_wdata[0]))
                   | (sh_tx_req & (tx_level == '0));
            ovf_q <= (ovf_q & ~((acc == ACC_STAT_WR) & reg_wdata[1]))
                   | (sh_rx_valid & (rx_push_done == '0));
        end
    end

    assign tx_underflow = unf_q;
    assign rx_overflow  = ovf_q;
    assign sh_tx_data   = tx_head[0];

    spi_lane_order u_order (
        .msb_first (cfg_q[ORDER_BIT]),
        .tx_word   (reg_wdata),
        .tx_bytes  (tx_bytes),
        .rx_bytes  (rx_bytes),
        .rx_take   (rx_take),
        .rx_word   (rx_word)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_W(4), .POP_W(1)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_want (tx_want),
        .push_data (tx_bytes),
        .push_done (tx_done),
        .pop_want  (lane_cnt_t'(sh_tx_req)),
        .pop_done  (tx_pop_done),
        .pop_data  (tx_head),
        .level     (tx_level)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_W(1), .POP_W(4)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_want (lane_cnt_t'(sh_rx_valid)),
        .push_data (sh_rx_data),
        .push_done (rx_push_done),
        .pop_want  (rx_want),
        .pop_done  (rx_take),
        .pop_data  (rx_bytes),
        .level     (rx_level)
    );

    // R8
    unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_tx_req && tx_level == '0) |=> tx_underflow);

    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_rx_valid && rx_level == LW'(FIFO_DEPTH)) |=> rx_overflow);

    // R9
    ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_rx_valid && rx_level == LW'(FIFO_DEPTH) && acc != ACC_RX_RD)
        |=> rx_level == LW'(FIFO_DEPTH));

    // R6
    rx_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_RX_RD && rx_level == '0) |-> reg_rdata == 32'd0);

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_tx_req && tx_done == '0) |=> $stable(tx_level));

endmodule

// File: tb/spi_word_packer_tb.sv
module spi_word_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sh_tx_req = 1'b0;
    logic [7:0]  sh_tx_data;
    logic        sh_rx_valid = 1'b0;
    logic [7:0]  sh_rx_data = '0;
    logic        tx_underflow, rx_overflow;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_word_packer #(.ADDR_W(8), .XFER_BYTES(4), .FIFO_DEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sh_tx_req(sh_tx_req), .sh_tx_data(sh_tx_data),
        .sh_rx_valid(sh_rx_valid), .sh_rx_data(sh_rx_data),
        .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_valid = 1'b0;
    endtask

    task automatic tx_take(output logic [7:0] b);
        @(negedge clk);
        sh_tx_req = 1'b1;
        #1 b = sh_tx_data;
        @(posedge clk); #1;
        sh_tx_req = 1'b0;
    endtask

    task automatic rx_give(input logic [7:0] b);
        @(negedge clk);
        sh_rx_valid = 1'b1; sh_rx_data = b;
        @(posedge clk); #1;
        sh_rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_rd(8'h04, d); chk("R1 status", d, 32'h0);
        reg_rd(8'h00, d); chk("R1 config", d, 32'h0);
        reg_rd(8'h10, d); chk("R1 threshold", d, 32'h1);
        reg_rd(8'h0C, d); chk("R1 empty rx read", d, 32'h0);
        chk("R1 flags", {30'd0, rx_overflow, tx_underflow}, 32'h0);
    endtask

    task automatic t_tx_little();
        logic [7:0] b;
        reg_wr(8'h08, 32'h44332211);
        for (int k = 0; k < 4; k++) begin
            tx_take(b); chk("R2/R7 lsb-first byte", 32'(b), 32'(8'h11 * (k + 1)));
        end
    endtask

    task automatic t_tx_big();
        logic [7:0] b;
        logic [31:0] w = 32'hA1B2C3D4;
        reg_wr(8'h00, 32'h0400_0000);
        reg_wr(8'h08, w);
        for (int k = 0; k < 4; k++) begin
            tx_take(b); chk("R3 msb-first byte", 32'(b), 32'(w[8*(3-k) +: 8]));
        end
        reg_wr(8'h84, 32'h1234_5678);
        tx_take(b); chk("R4 msb-first TX2 first", 32'(b), 32'h12);
        tx_take(b); chk("R4 msb-first TX2 second", 32'(b), 32'h34);
        reg_wr(8'h00, 32'h0);
    endtask

    task automatic t_partial();
        logic [7:0] b;
        logic [31:0] d;
        reg_wr(8'h80, 32'h5555_55AA);
        reg_wr(8'h84, 32'h6666_CCBB);
        reg_wr(8'h88, 32'h77FF_EEDD);
        for (int k = 0; k < 6; k++) begin
            tx_take(b); chk("R4 partial push byte", 32'(b), 32'(8'hAA + 8'(k * 8'h11)));
        end
        chk("R4 no flag before drain", 32'(tx_underflow), 32'h0);
        tx_take(b);
        reg_rd(8'h04, d); chk("R4/R8 exact count, then underflow", d, 32'h1);
        chk("R8 port flag", 32'(tx_underflow), 32'h1);
        reg_wr(8'h04, 32'h1);
        reg_rd(8'h04, d); chk("R10 clear underflow", d, 32'h0);
    endtask

    task automatic t_full();
        logic [7:0] b;
        logic [31:0] d;
        reg_wr(8'h08, 32'h03020100);
        reg_wr(8'h08, 32'h07060504);
        reg_wr(8'h08, 32'h0B0A0908);
        for (int k = 0; k < 8; k++) begin
            tx_take(b); chk("R5 kept byte", 32'(b), 32'(k));
        end
        chk("R5 no underflow yet", 32'(tx_underflow), 32'h0);
        tx_take(b);
        reg_rd(8'h04, d); chk("R5/R8 excess dropped", d, 32'h1);
        reg_wr(8'h04, 32'h1);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        for (int k = 0; k < 5; k++) rx_give(8'h10 + 8'(k));
        reg_rd(8'h0C, d); chk("R6 full word lsb-first", d, 32'h13121110);
        reg_rd(8'h0C, d); chk("R6 partial word zero-filled", d, 32'h00000014);
        reg_rd(8'h0C, d); chk("R6 empty read", d, 32'h0);
        rx_give(8'h21); rx_give(8'h22);
        reg_wr(8'h00, 32'h0400_0000);
        reg_rd(8'h0C, d); chk("R6 msb-first partial", d, 32'h21220000);
        reg_wr(8'h00, 32'h0);
    endtask

    task automatic t_ovf();
        logic [31:0] d;
        for (int k = 0; k < 8; k++) rx_give(8'h30 + 8'(k));
        chk("R9 no overflow at exactly full", 32'(rx_overflow), 32'h0);
        rx_give(8'h38);
        reg_rd(8'h04, d); chk("R9 overflow flag", d, 32'h2);
        reg_wr(8'h04, 32'h1);
        reg_rd(8'h04, d); chk("R10 other bit keeps overflow", d, 32'h2);
        reg_wr(8'h04, 32'h0);
        chk("R10 zero write keeps overflow", 32'(rx_overflow), 32'h1);
        reg_rd(8'h0C, d); chk("R9 first word", d, 32'h33323130);
        reg_rd(8'h0C, d); chk("R9 second word", d, 32'h37363534);
        reg_rd(8'h0C, d); chk("R9 extra byte dropped", d, 32'h0);
        reg_wr(8'h04, 32'h2);
        reg_rd(8'h04, d); chk("R10 clear overflow", d, 32'h0);
    endtask

    task automatic t_thr();
        logic [31:0] d;
        reg_wr(8'h10, 32'h5);
        reg_rd(8'h10, d); chk("R11 threshold write", d, 32'h5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_tx_little();
        t_tx_big();
        t_partial();
        t_full();
        t_rx();
        t_ovf();
        t_thr();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule